// File: doc/BRIEF.md
# Per-Channel Edge/Level Interrupt Detector

This block is the front end of an interrupt controller. It watches a bank of raw interrupt request lines, brings each one into the local clock domain, and keeps one pending bit per channel. A per-channel trigger-mode bit chooses how that bit behaves. In edge mode a rising edge on the line latches a request that stays set until the channel is acknowledged, so only one device can own the line. In level mode the pending bit simply reflects the line, so several open-drain sources can share one line and the request lasts as long as any of them holds it high.

Downstream logic handles priority and vectors. It reads the pending vector and the combined interrupt output, and it pulses the per-channel acknowledge once it has taken a request. Software owns the trigger-mode bits. When a channel's mode is changed, its pending state is flushed so that a request latched under the old rules cannot leak into the new mode.

Top module: `irq_sense_bank`

## Requirements
- R1: While reset is applied and after it is released, every pending bit and `irq_any` are 0 and every channel works in edge mode until `trig_level` says otherwise.
- R2: In edge mode (`trig_level` bit = 0), a 0-to-1 change on `req_raw` sets that channel's pending bit exactly 3 clock edges after the input changes: two synchronizer flops, then the pending register.
- R3: In edge mode, a set pending bit stays set when the request line falls, for as long as no acknowledge arrives.
- R4: In edge mode, a one-cycle high pulse on a channel's `ack` clears its pending bit at the next clock edge. If a new rising edge is detected in that same cycle, the set wins and the bit stays 1.
- R5: In edge mode, several rising edges that arrive before an acknowledge merge into a single pending bit, and one acknowledge clears it.
- R6: In level mode (`trig_level` bit = 1), the pending bit follows the request line with a delay of 3 clock edges, in both the rising and the falling direction.
- R7: In level mode, an acknowledge has no effect. The pending bit stays 1 while the line is high.
- R8: A change of a channel's `trig_level` bit clears that channel's pending bit at the next clock edge. After that, the new mode's rules apply.
- R9: `irq_any` is 1 exactly when at least one pending bit is 1, in the same cycle.
- R10: Channels are independent. Input, mode or acknowledge activity on one channel never changes another channel's pending bit.
- R11: In edge mode, a line that stays high after an acknowledge does not raise the request again. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_raw | input | NUM_CH | Raw asynchronous request lines, active high |
| trig_level | input | NUM_CH | Trigger mode per channel: 0 = edge, 1 = level |
| ack | input | NUM_CH | Per-channel acknowledge strobe, active high |
| pending | output | NUM_CH | Per-channel pending request bits |
| irq_any | output | 1 | OR of all pending bits |

## Verification
A change on a raw line shows up on `pending` three edges later. An acknowledge or a mode change acts at the very next edge, and `irq_any` follows `pending` in the same cycle. The driver records every stimulus, together with the full expected pending vector, in a queue tagged with the cycle count at which that vector is due (current cycle plus 3, plus 1, or plus 0). The monitor samples a quarter period after each falling edge and compares only the entries that are due in that cycle, so every check lands on the exact cycle and not just eventually. The bench also checks the cycles just before a result is due, for example that pending is still 0 two edges after a rising edge, so off-by-one latency errors are caught.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;

endpackage

// File: rtl/irqs_rst_sync.sv
module irqs_rst_sync #(
  parameter int unsigned STAGES = irqs_pkg::DEF_RST_STAGES
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[STAGES-1];

endmodule

// File: rtl/irqs_sync_chain.sv
module irqs_sync_chain #(
  parameter int unsigned STAGES = irqs_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] flop_q;
  logic [STAGES-1:0] flop_d;

  always_comb begin
    flop_d = {flop_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flop_q <= '0;
    end else begin
      flop_q <= flop_d;
    end
  end

  assign q_o = flop_q[STAGES-1];

endmodule

// File: rtl/irqs_chan.sv
module irqs_chan
  import irqs_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic line_i,
  input  logic level_i,
  input  logic ack_i,
  output logic pend_o
);

  trig_mode_e mode_q, mode_d;
  logic       mode_en;
  logic       mode_chg;
  logic       line_prev_q;
  logic       rise;
  logic       pend_q, pend_d;
  logic       pend_en;

  // Mode tracking and change detection
  always_comb begin
    mode_d   = trig_mode_e'(level_i);
    mode_chg = (mode_d != mode_q);
    mode_en  = mode_chg;
  end

  // Rising edge seen on the synchronized line
  always_comb begin
    rise = line_i & ~line_prev_q;
  end

  // Pending next state
  always_comb begin
    pend_d = pend_q;
    if (mode_chg) begin
      pend_d = 1'b0;
    end else if (mode_q == TRIG_LEVEL) begin
      pend_d = line_i;
    end else if (rise) begin
      pend_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TRIG_EDGE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      line_prev_q <= 1'b0;
    end else begin
      line_prev_q <= line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R2: a detected rise in stable edge mode latches a request
  assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_chg && mode_q == TRIG_EDGE && line_i && !line_prev_q) |=> pend_q);

  // R3: an unacknowledged edge request is sticky
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_chg && mode_q == TRIG_EDGE && pend_q && !ack_i) |=> pend_q);

  // R4: acknowledge without a coincident rise clears the request
  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_chg && mode_q == TRIG_EDGE && ack_i && !(line_i && !line_prev_q)) |=> !pend_q);

  // R6: level mode mirrors the synchronized line
  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_chg && mode_q == TRIG_LEVEL) |=> (pend_q == $past(line_i)));

  // R8: a mode switch flushes the request
  assert_mode_flush_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    mode_chg |=> !pend_q);

endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SYNC_STAGES = irqs_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_raw,
  input  logic [NUM_CH-1:0] trig_level,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] pending,
  output logic              irq_any
);

  logic              rst_int_n;
  logic [NUM_CH-1:0] req_sync;
  logic [NUM_CH-1:0] pend_vec;

  irqs_rst_sync #(
    .STAGES(irqs_pkg::DEF_RST_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_ni(rst_n),
    .rst_no (rst_int_n)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    irqs_sync_chain #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk   (clk),
      .rst_ni(rst_int_n),
      .d_i   (req_raw[ch]),
      .q_o   (req_sync[ch])
    );

    irqs_chan u_chan (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .line_i (req_sync[ch]),
      .level_i(trig_level[ch]),
      .ack_i  (ack[ch]),
      .pend_o (pend_vec[ch])
    );
  end

  assign pending = pend_vec;
  assign irq_any = |pend_vec;

  // R1: nothing is pending while the internal reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_int_n && !$isunknown(pend_vec)) |-> (pend_vec == '0));

endmodule

// File: tb/tb_irq_sense_bank.sv
`timescale 1ns/1ps
module tb_irq_sense_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int WDOG_LIMIT = 5000;

  typedef struct {
    int           due;
    logic [NCH-1:0] exp;
    string        req;
  } exp_item_t;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] req_raw;
  logic [NCH-1:0] trig_level;
  logic [NCH-1:0] ack;
  logic [NCH-1:0] pending;
  logic           irq_any;

  int        cyc;
  int        n_vec;
  int        n_bad;
  bit        done;
  exp_item_t sb_q[$];

  irq_sense_bank #(.NUM_CH(NCH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_raw   (req_raw),
    .trig_level(trig_level),
    .ack       (ack),
    .pending   (pending),
    .irq_any   (irq_any)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expected pending vector due after dly edges
  task automatic expect_at(input int dly, input logic [NCH-1:0] exp, input string req);
    exp_item_t it;
    it.due = cyc + dly;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: a quarter period after each falling edge, compare due entries
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    for (int i = 0; i < sb_q.size(); ) begin
      if (sb_q[i].due == cyc) begin
        n_vec++;
        if (pending !== sb_q[i].exp || irq_any !== (|sb_q[i].exp)) begin
          n_bad++;
          $display("FAIL %s cycle %0d: pending=%b irq_any=%b expected pending=%b irq_any=%b",
                   sb_q[i].req, cyc, pending, irq_any, sb_q[i].exp, |sb_q[i].exp);
        end
        sb_q.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic finish_run;
    if (sb_q.size() != 0) begin
      n_bad += sb_q.size();
      $display("FAIL scoreboard: %0d expected vectors never compared", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; req_raw = '0; trig_level = '0; ack = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: clean state after reset
    expect_at(0, 4'b0000, "R1");
    tick(1);

    // R2 / R3: edge on ch0, latency 3, sticky after line falls
    req_raw = 4'b0001;
    expect_at(2, 4'b0000, "R2");
    expect_at(3, 4'b0001, "R2");
    tick(4);
    req_raw = 4'b0000;
    expect_at(3, 4'b0001, "R3");
    tick(4);

    // R4: acknowledge clears at next edge
    ack = 4'b0001;
    expect_at(1, 4'b0000, "R4");
    tick(1); ack = '0; tick(1);

    // R11: line held high after ack does not re-raise in edge mode
    req_raw = 4'b0001;
    expect_at(3, 4'b0001, "R2");
    tick(4);
    ack = 4'b0001;
    expect_at(1, 4'b0000, "R11");
    tick(1); ack = '0;
    expect_at(3, 4'b0000, "R11");
    tick(4);
    req_raw = '0; tick(4);

    // R5: two edges on ch1 merge, one ack clears
    req_raw = 4'b0010; tick(2);
    req_raw = 4'b0000; tick(2);
    req_raw = 4'b0010; tick(2);
    req_raw = 4'b0000; tick(4);
    expect_at(0, 4'b0010, "R5");
    ack = 4'b0010;
    expect_at(1, 4'b0000, "R5");
    tick(1); ack = '0;
    expect_at(2, 4'b0000, "R5");
    tick(3);

    // R4: rise coincident with ack wins
    req_raw = 4'b0010; tick(4);
    req_raw = 4'b0000; tick(3);
    req_raw = 4'b0010; tick(2);
    ack = 4'b0010;
    expect_at(1, 4'b0010, "R4");
    tick(1); ack = '0;
    expect_at(0, 4'b0010, "R4");
    tick(1);
    ack = 4'b0010;
    expect_at(1, 4'b0000, "R4");
    tick(1); ack = '0;
    req_raw = '0; tick(4);

    // R6 / R7 / R8: ch2 switched to level
    trig_level = 4'b0100;
    expect_at(1, 4'b0000, "R8");
    tick(2);
    req_raw = 4'b0100;
    expect_at(2, 4'b0000, "R6");
    expect_at(3, 4'b0100, "R6");
    tick(4);
    ack = 4'b0100;
    expect_at(1, 4'b0100, "R7");
    tick(1); ack = '0;
    expect_at(1, 4'b0100, "R7");
    tick(2);

    // R10: ch0 edge alongside level ch2, ack on ch0 leaves ch2
    req_raw = 4'b0101;
    expect_at(3, 4'b0101, "R10");
    tick(4);
    ack = 4'b0001;
    expect_at(1, 4'b0100, "R10");
    tick(1); ack = '0; tick(1);
    req_raw = 4'b0100; tick(4);
    req_raw = 4'b0000;
    expect_at(2, 4'b0100, "R6");
    expect_at(3, 4'b0000, "R6");
    tick(4);

    // R8: ch3 edge pending, switched to level then back with line high
    req_raw = 4'b1000;
    expect_at(3, 4'b1000, "R2");
    tick(4);
    trig_level = 4'b1100;
    expect_at(1, 4'b0000, "R8");
    expect_at(2, 4'b1000, "R8");
    tick(3);
    trig_level = 4'b0100;
    expect_at(1, 4'b0000, "R8");
    expect_at(3, 4'b0000, "R8");
    tick(4);
    req_raw = '0; tick(4);
    trig_level = '0;
    expect_at(1, 4'b0000, "R9");
    tick(3);

    done = 1'b1;
    finish_run();
  end

endmodule